// File: doc/BRIEF.md
# Thread-Banked Register File

This block is the operand store of a fine-grained multithreaded core. Every thread owns sixteen 32-bit general registers and a small set of special registers, one of which is the status word. Two operands are read per cycle and one result is written. The general registers sit in two identical single-read, single-write memories. Every write lands in both copies at the same location, so each copy serves one read port on its own. The memory location is the thread number placed above the 4-bit register number. With the default 4-bit thread number each copy holds 256 words for 16 threads. With a 5-bit thread number each copy holds 512 words for 32 threads.

Operand codes are 6 bits wide. The two top bits pick the kind of source. Codes 0 to 15 name general registers. Codes 16 to 31 name the per-thread special registers; code 16 is the status word and code 17 is a second per-thread word. Codes 32 to 63 read a fixed table of 32 bit masks. The table is computed, not stored. Its lower half holds single-bit set masks and its upper half holds single-bit clear masks, so an AND with one entry clears one status flag. Reads are synchronous: the operand appears one clock after its code is presented. The read thread and the write thread are separate inputs, because write-back belongs to an older instruction, often from another thread.

Top module: `thread_rf_top`

## Requirements
- R1: While reset is held, and right after it is released, both read outputs are zero. Every special register of every thread starts at zero.
- R2: A general register written in one cycle returns the written value when its code (0..15) is presented in any later cycle. The data appears on the read output one clock after the code is presented.
- R3: The two read ports work independently. In one cycle they may read the same code or two different codes, each of any kind.
- R4: Registers of different threads are separate. A write with write thread T changes only thread T's copy of that register.
- R5: When a location is read in the same cycle that it is written, the read returns the value it held before that write.
- R6: Codes 16 (status) and 17 are writable per-thread special registers. They read back with the same one-cycle latency.
- R7: Special codes 18..31 have no storage. They read as zero, and writes to them change no register.
- R8: Code 32+k returns constant entry k one clock later. For k < 16 the entry is 1 << (k+2), a set mask. For k >= 16 it is the inverse of 1 << (k-14), a clear mask. So entry 22 (code 54) is 0xFFFFFEFF.
- R9: Writes to codes 32..63 are dropped. They do not reach the general register whose number equals the low four code bits, and they do not reach any special register.
- R10: With the write enable low, no general or special register changes, whatever the write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tid | input | 4 | Thread whose operands are read |
| rd_addr_a | input | 6 | Operand code, port A |
| rd_addr_b | input | 6 | Operand code, port B |
| wr_en | input | 1 | Write enable |
| wr_tid | input | 4 | Thread being written |
| wr_addr | input | 6 | Destination code |
| wr_data | input | 32 | Write data |
| rd_data_a | output | 32 | Operand A, one clock after its code |
| rd_data_b | output | 32 | Operand B, one clock after its code |

## Verification
The assertions assume that rd_tid, wr_tid, wr_en and both codes are at known levels on every clock once reset is released. They also assume that reset is applied before the first read of a special register. The general-register memories have no reset, so the checks apply only to locations that have been written. The stimulus meets this by writing every general register of every thread before any unconstrained read. Its inputs change only on the falling clock edge, and every code, thread number and data value it drives is fully defined.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  localparam int RF_DATA_W = 32;
  localparam int RF_CODE_W = 6;
  localparam int RF_REG_W  = 4;

  typedef enum logic [1:0] {
    CLS_GPR = 2'd0,
    CLS_SPR = 2'd1,
    CLS_ROM = 2'd2
  } rf_cls_e;

  // Upper code bits pick the source kind.
  function automatic rf_cls_e rfb_classify(input logic [RF_CODE_W-1:0] code);
    if (code[5])      return CLS_ROM;
    else if (code[4]) return CLS_SPR;
    else              return CLS_GPR;
  endfunction

  // Mask table: low half sets bit k+2, high half clears bit k-14.
  function automatic logic [RF_DATA_W-1:0] rfb_const(input logic [4:0] k);
    logic [RF_DATA_W-1:0] one_hot;
    if (!k[4]) begin
      one_hot = RF_DATA_W'(1) << (k[3:0] + 5'd2);
      return one_hot;
    end
    one_hot = RF_DATA_W'(1) << (k[3:0] + 5'd2);
    return ~one_hot;
  endfunction

endpackage

// File: rtl/rfb_ram_bank.sv
module rfb_ram_bank #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wdata;
  end

  // Registered read; a same-cycle write is not yet visible.
  always_ff @(posedge clk) begin
    rdata <= mem[ra];
  end

  AST_RAM_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && ra == $past(wa)) |=> rdata == $past(wdata, 2)); // R2

endmodule

// File: rtl/rfb_spr_bank.sv
module rfb_spr_bank
  import rfb_pkg::*;
#(
  parameter int THREAD_W = 4,
  parameter int NUM_SPR  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [THREAD_W-1:0]           wtid,
  input  logic [RF_REG_W-1:0]           wcode,
  input  logic [RF_DATA_W-1:0]          wdata,
  input  logic [THREAD_W-1:0]           rtid,
  input  logic [1:0][RF_REG_W-1:0]      rcode,
  output logic [1:0][RF_DATA_W-1:0]     rval
);
  localparam int NTHR = 1 << THREAD_W;

  logic [NTHR-1:0][NUM_SPR-1:0][RF_DATA_W-1:0] spr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spr_q <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        for (int s = 0; s < NUM_SPR; s++) begin
          if (we && wtid == THREAD_W'(t) && wcode == RF_REG_W'(s))
            spr_q[t][s] <= wdata;
        end
      end
    end
  end

  // Unimplemented codes fall through to zero.
  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      rval[p] = '0;
      for (int s = 0; s < NUM_SPR; s++) begin
        if (rcode[p] == RF_REG_W'(s)) rval[p] = spr_q[rtid][s];
      end
    end
  end

  AST_SPR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(spr_q)); // R10

endmodule

// File: rtl/rfb_read_port.sv
module rfb_read_port
  import rfb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RF_CODE_W-1:0]  code,
  input  logic [RF_DATA_W-1:0]  spr_val,
  input  logic [RF_DATA_W-1:0]  ram_q,
  output logic [RF_DATA_W-1:0]  rd_data
);
  rf_cls_e              cls_now;
  rf_cls_e              cls_q;
  logic [RF_DATA_W-1:0] side_q;

  assign cls_now = rfb_classify(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= CLS_ROM;
      side_q <= '0;
    end else begin
      cls_q  <= cls_now;
      side_q <= (cls_now == CLS_SPR) ? spr_val : rfb_const(code[4:0]);
    end
  end

  assign rd_data = (cls_q == CLS_GPR) ? ram_q : side_q;

endmodule

// File: rtl/thread_rf_top.sv
module thread_rf_top
  import rfb_pkg::*;
#(
  parameter int THREAD_W = 4,
  parameter int NUM_SPR  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [THREAD_W-1:0]   rd_tid,
  input  logic [RF_CODE_W-1:0]  rd_addr_a,
  input  logic [RF_CODE_W-1:0]  rd_addr_b,
  input  logic                  wr_en,
  input  logic [THREAD_W-1:0]   wr_tid,
  input  logic [RF_CODE_W-1:0]  wr_addr,
  input  logic [RF_DATA_W-1:0]  wr_data,
  output logic [RF_DATA_W-1:0]  rd_data_a,
  output logic [RF_DATA_W-1:0]  rd_data_b
);
  localparam int AW = THREAD_W + RF_REG_W;
  localparam logic [RF_REG_W-1:0] SPR_LIM = RF_REG_W'(NUM_SPR);

  // Named write strobes, one per destination kind.
  logic gpr_wr_stb;
  logic spr_wr_stb;
  assign gpr_wr_stb = wr_en && (rfb_classify(wr_addr) == CLS_GPR);
  assign spr_wr_stb = wr_en && (rfb_classify(wr_addr) == CLS_SPR)
                      && (wr_addr[3:0] < SPR_LIM);

  logic [1:0][RF_CODE_W-1:0] code_p;
  logic [1:0][RF_REG_W-1:0]  spr_code_p;
  logic [1:0][RF_DATA_W-1:0] spr_val_p;
  logic [1:0][RF_DATA_W-1:0] ram_q_p;
  logic [1:0][RF_DATA_W-1:0] rd_data_p;

  assign code_p[0] = rd_addr_a;
  assign code_p[1] = rd_addr_b;

  rfb_spr_bank #(.THREAD_W(THREAD_W), .NUM_SPR(NUM_SPR)) u_spr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (spr_wr_stb),
    .wtid  (wr_tid),
    .wcode (wr_addr[3:0]),
    .wdata (wr_data),
    .rtid  (rd_tid),
    .rcode (spr_code_p),
    .rval  (spr_val_p)
  );

  // One memory copy and one output stage per read port.
  for (genvar p = 0; p < 2; p++) begin : g_port
    assign spr_code_p[p] = code_p[p][3:0];

    rfb_ram_bank #(.AW(AW), .DW(RF_DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (gpr_wr_stb),
      .wa    ({wr_tid, wr_addr[3:0]}),
      .wdata (wr_data),
      .ra    ({rd_tid, code_p[p][3:0]}),
      .rdata (ram_q_p[p])
    );

    rfb_read_port u_rport (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (code_p[p]),
      .spr_val (spr_val_p[p]),
      .ram_q   (ram_q_p[p]),
      .rd_data (rd_data_p[p])
    );
  end

  assign rd_data_a = rd_data_p[0];
  assign rd_data_b = rd_data_p[1];

  AST_ROM_CLEAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == 6'd54) |=> rd_data_b == 32'hFFFF_FEFF); // R8

  AST_SPR_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a[5:4] == 2'b01 && rd_addr_a[3:0] >= SPR_LIM) |=> rd_data_a == '0); // R7

  AST_GPR_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpr_wr_stb, spr_wr_stb, wr_en && wr_addr[5]})); // R9

endmodule

// File: tb/thread_rf_top_tb_top.sv
module thread_rf_top_tb_top;
  localparam int NTHR = 16;
  localparam int NSPR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_tid = '0;
  logic [5:0]  rd_addr_a = 6'd32;
  logic [5:0]  rd_addr_b = 6'd32;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_tid = '0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data_a;
  logic [31:0] rd_data_b;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] gpr_m [NTHR][16];
  logic [31:0] spr_m [NTHR][NSPR];

  always #4 clk = ~clk;

  thread_rf_top dut_i (
    .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  function automatic logic [31:0] mask_of(int k);
    longint bitval;
    if (k < 16) begin
      bitval = 64'd1 << (k + 2);
      return bitval[31:0];
    end
    bitval = 64'd1 << (k - 14);
    return 32'hFFFF_FFFF - bitval[31:0];
  endfunction

  function automatic logic [31:0] model_read(int t, int code);
    if (code < 16)        return gpr_m[t][code];
    if (code < 16 + NSPR) return spr_m[t][code-16];
    if (code < 32)        return 32'h0;
    return mask_of(code - 32);
  endfunction

  function automatic string kind_tag(int code);
    if (code < 16)        return "R2";
    if (code < 16 + NSPR) return "R6";
    if (code < 32)        return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, string port, int code,
                       logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s/%s port %s code %0d: actual=%h expected=%h",
               tag, kind_tag(code), port, code, act, exp);
    end
  endtask

  // Drive at a falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(string tag, int t, int ca, int cb,
                      bit we, int wt, int wa, logic [31:0] wd);
    logic [31:0] ea, eb;
    rd_tid = 4'(t); rd_addr_a = 6'(ca); rd_addr_b = 6'(cb);
    wr_en = we; wr_tid = 4'(wt); wr_addr = 6'(wa); wr_data = wd;
    @(posedge clk);
    ea = model_read(t, ca);
    eb = model_read(t, cb);
    if (we) begin
      if (wa < 16)             gpr_m[wt][wa] = wd;
      else if (wa < 16 + NSPR) spr_m[wt][wa-16] = wd;
    end
    @(negedge clk);
    check(tag, "A", ca, rd_data_a, ea);
    check(tag, "B", cb, rd_data_b, eb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int t = 0; t < NTHR; t++)
      for (int s = 0; s < NSPR; s++) spr_m[t][s] = '0;
    repeat (3) @(negedge clk);
    check("R1", "A", 32, rd_data_a, 32'h0);
    check("R1", "B", 32, rd_data_b, 32'h0);
    rst_n = 1'b1;
    check("R1", "A", 32, rd_data_a, 32'h0);
    check("R1", "B", 32, rd_data_b, 32'h0);

    // R1: special registers start at zero in every thread.
    step("R1", 9, 16, 17, 0, 0, 0, 0);
    step("R1", 0, 17, 16, 0, 0, 0, 0);

    // Fill every general register; sweep all mask entries meanwhile (R8).
    for (int t = 0; t < NTHR; t++)
      for (int r = 0; r < 16; r++)
        step("R8", t, 32 + r, 48 + r, 1, t, r,
             32'hA500_0000 ^ (t << 8) ^ (r * 32'h0001_1111));

    // R8: the flag-clearing entry.
    step("R8", 3, 54, 54, 0, 0, 0, 0);

    // R4: same register number, two threads.
    step("R4", 2, 3, 3, 1, 1, 3, 32'hDEAD_0001);
    step("R4", 1, 3, 3, 0, 0, 0, 0);
    step("R4", 2, 3, 3, 0, 0, 0, 0);

    // R5: read and write of the same location in one cycle.
    step("R5", 4, 7, 7, 1, 4, 7, 32'h1234_5678);
    step("R5", 4, 7, 6, 0, 0, 0, 0);

    // R3: ports reading different kinds in one cycle.
    step("R3", 4, 7, 54, 0, 0, 0, 0);

    // R6: status write in thread 5, thread 6 untouched.
    step("R6", 5, 16, 17, 1, 5, 16, 32'h0000_0F0F);
    step("R6", 5, 16, 17, 1, 5, 17, 32'hCAFE_F00D);
    step("R6", 6, 16, 17, 0, 0, 0, 0);
    step("R6", 5, 16, 17, 0, 0, 0, 0);

    // R7: writes to codes without storage leave everything intact.
    step("R7", 5, 18, 31, 1, 5, 18, 32'hFFFF_FFFF);
    step("R7", 5, 18, 2, 0, 0, 0, 0);
    step("R7", 5, 16, 17, 0, 0, 0, 0);

    // R9: write to code 35 must not reach register 3 or a special register.
    step("R9", 8, 3, 16, 1, 8, 35, 32'h5555_AAAA);
    step("R9", 8, 3, 16, 1, 8, 48, 32'h7777_7777);
    step("R9", 8, 3, 0, 0, 0, 0, 0);

    // R10: enable low with live write inputs.
    rd_tid = 4'd9; rd_addr_a = 6'd9; rd_addr_b = 6'd16;
    step("R10", 9, 9, 16, 0, 9, 9, 32'hBAD0_BAD0);
    step("R10", 9, 9, 16, 0, 9, 16, 32'hBAD0_BAD1);
    step("R10", 9, 9, 16, 0, 0, 0, 0);

    // Mixed traffic across all kinds, threads and ports (R2, R3, R4, R6).
    for (int i = 0; i < 600; i++)
      step("R3", $urandom_range(NTHR-1), $urandom_range(63), $urandom_range(63),
           1'($urandom_range(1)), $urandom_range(NTHR-1), $urandom_range(63),
           $urandom);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule